// File: doc/BRIEF.md
# Address-Latched Split-Window Bank Mapper

This block translates CPU addresses into ROM addresses for a cartridge that holds 128 KB of ROM, organised as eight banks of 16 KB. The CPU space from 0x4000 up to 0xFFFF is split into 8 KB pages. Most of these pages are tied to halves of the two highest banks, 6 and 7. In both of those banks the upper half sits at the lower CPU address, so the halves are swapped. The two pages between 0xA000 and 0xDFFF form one 16 KB window into whichever bank is currently selected.

The bank is selected by the address of a write, not by its data. A write to any of eight consecutive strobe addresses starting at 0xFF80 loads the low three address bits into the bank register. The block has no data input.

A boot override input reflects the system control bit that enables the cartridge. While that input is low, the top boot-ROM range reads from the boot ROM instead of the cartridge. Address decoding is purely combinational. Only the bank register is clocked.

Top module: `bank_mapper`

## Requirements
- R1: While `rom_sel` is high and the address is in 0x4000–0x5FFF, `rom_addr` = 6·0x4000 + 0x2000 + (addr − 0x4000), which is the upper half of bank 6.
- R2: For addresses 0x6000–0x7FFF, `rom_addr` = 6·0x4000 + (addr − 0x6000), which is the lower half of bank 6.
- R3: For addresses 0x8000–0x9FFF, `rom_addr` = 7·0x4000 + 0x2000 + (addr − 0x8000), which is the upper half of bank 7.
- R4: For addresses 0xE000–0xFFFF, `rom_addr` = 7·0x4000 + (addr − 0xE000), which is the lower half of bank 7.
- R5: For addresses 0xA000–0xDFFF, `rom_addr` = bank·0x4000 + (addr − 0xA000), where bank is the 3-bit bank register.
- R6: A write (`wr_en` high at a rising clock edge) to an address from 0xFF80 to 0xFF87 loads address bits [2:0] into the bank register. The new bank is visible from the next cycle.
- R7: A write to any address outside 0xFF80–0xFF87 leaves the bank register unchanged.
- R8: After reset the bank register is 0.
- R9: While `cart_en` is low, an address at or above 0x10000 − BOOT_BYTES (0xF000 by default) gives `boot_sel` = 1 and `rom_sel` = 0. While `cart_en` is high, `boot_sel` is 0.
- R10: Addresses below 0x4000 give `rom_sel` = 0 and `boot_sel` = 0. Any other address that is not overridden by the boot ROM gives `rom_sel` = 1.
- R11: A strobe address presented with `wr_en` low does not change the bank register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| wr_en | input | 1 | CPU write strobe for the current address |
| cart_en | input | 1 | Cartridge enable; low selects the boot ROM at the top of memory |
| rom_addr | output | 17 | Cartridge ROM address (valid while rom_sel is high) |
| rom_sel | output | 1 | Cartridge ROM is the target of this address |
| boot_sel | output | 1 | Boot ROM overrides the cartridge for this address |

## Verification
The bank register is the only state, and it reaches the ports only through the window pages. A wrong bank therefore does not show on any read outside 0xA000–0xDFFF. It shows in the top three bits of `rom_addr` on the first window read after the faulty write, which can be several accesses later.

The bench mixes random traffic, including writes close to the strobe range, with reads of the window. Each window read compares the bank against a model bank that the bench keeps itself. An off-by-one in the strobe decode, or a latch that takes its value from the wrong bits, is therefore caught at the next window access.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int          BANK_W      = 3,
  parameter logic [15:0] STROBE_BASE = 16'hFF80,
  parameter int          BOOT_BYTES  = 4096,
  localparam int         WIN_W       = 14,
  localparam int         ROM_AW      = BANK_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              wr_en,
  input  logic              cart_en,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_sel,
  output logic              boot_sel
);

  localparam logic [BANK_W-1:0] LOW_FIX  = BANK_W'(6);
  localparam logic [BANK_W-1:0] HIGH_FIX = BANK_W'(7);
  localparam logic [16:0]       BOOT_LO  = 17'h10000 - 17'(BOOT_BYTES);

  logic [BANK_W-1:0] bank_q;
  logic              strobe_hit;

  assign strobe_hit = cpu_addr[15:BANK_W] == STROBE_BASE[15:BANK_W];

  always_ff @(posedge clk) begin
    if (!rst_n)
      bank_q <= '0;
    else if (wr_en && strobe_hit)
      bank_q <= cpu_addr[BANK_W-1:0];
  end

  assign boot_sel = !cart_en && ({1'b0, cpu_addr} >= BOOT_LO);
  assign rom_sel  = (cpu_addr[15:14] != 2'b00) && !boot_sel;

  always_comb begin
    case (cpu_addr[15:13])
      3'd2:      rom_addr = {LOW_FIX,  1'b1, cpu_addr[12:0]};
      3'd3:      rom_addr = {LOW_FIX,  1'b0, cpu_addr[12:0]};
      3'd4:      rom_addr = {HIGH_FIX, 1'b1, cpu_addr[12:0]};
      3'd5,
      3'd6:      rom_addr = {bank_q, ~cpu_addr[13], cpu_addr[12:0]};
      3'd7:      rom_addr = {HIGH_FIX, 1'b0, cpu_addr[12:0]};
      default:   rom_addr = '0;
    endcase
  end

endmodule

// File: rtl/bank_mapper_checks.sv
module bank_mapper_checks #(
  parameter int BANK_W = 3,
  parameter int ROM_AW = BANK_W + 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic              wr_en,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_sel,
  input logic              boot_sel,
  input logic [BANK_W-1:0] bank_q
);

  logic strobe;
  assign strobe = cpu_addr[15:3] == 13'h1FF0;

  // R6
  p_strobe_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && strobe) |=> (bank_q == $past(cpu_addr[BANK_W-1:0])));

  // R7 and R11
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && strobe) |=> $stable(bank_q));

  // R9
  p_sel_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && boot_sel));

  // R5
  p_window_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && (cpu_addr[15:13] == 3'd5 || cpu_addr[15:13] == 3'd6))
      |-> (rom_addr[ROM_AW-1:14] == bank_q));

  // R4
  p_top_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && cpu_addr[15:13] == 3'd7) |-> (rom_addr[ROM_AW-1:13] == {BANK_W'(7), 1'b0}));

  // R10
  p_low_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> (!rom_sel && !boot_sel));

endmodule

bind bank_mapper bank_mapper_checks #(.BANK_W(BANK_W), .ROM_AW(ROM_AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_addr (cpu_addr),
  .wr_en    (wr_en),
  .rom_addr (rom_addr),
  .rom_sel  (rom_sel),
  .boot_sel (boot_sel),
  .bank_q   (bank_q)
);

// File: tb/tb_bank_mapper.sv
`timescale 1ns/1ps
module tb_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        wr_en = 1'b0;
  logic        cart_en = 1'b1;
  logic [16:0] rom_addr;
  logic        rom_sel, boot_sel;

  int checks = 0;
  int fails  = 0;
  int bank_m = 0;

  always #5 clk = ~clk;

  bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .wr_en(wr_en),
    .cart_en(cart_en), .rom_addr(rom_addr), .rom_sel(rom_sel), .boot_sel(boot_sel)
  );

  function automatic int exp_addr(int a, int b);
    if (a < 'h6000)      return 6 * 'h4000 + 'h2000 + (a - 'h4000);
    else if (a < 'h8000) return 6 * 'h4000 + (a - 'h6000);
    else if (a < 'hA000) return 7 * 'h4000 + 'h2000 + (a - 'h8000);
    else if (a < 'hE000) return b * 'h4000 + (a - 'hA000);
    else                 return 7 * 'h4000 + (a - 'hE000);
  endfunction

  function automatic string tag_of(int a);
    if (a < 'h4000)      return "R10";
    else if (a < 'h6000) return "R1";
    else if (a < 'h8000) return "R2";
    else if (a < 'hA000) return "R3";
    else if (a < 'hE000) return "R5";
    else                 return "R4";
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(int a, bit w, bit c, string tag = "");
    bit eb, es;
    string t;
    @(negedge clk);
    cpu_addr = a[15:0];
    wr_en    = w;
    cart_en  = c;
    #1;
    t  = (tag == "") ? tag_of(a) : tag;
    eb = !c && (a >= 'h10000 - 4096);
    es = (a >= 'h4000) && !eb;
    chk({t, "/R9 boot_sel"}, int'(boot_sel), int'(eb));
    chk({t, "/R10 rom_sel"}, int'(rom_sel), int'(es));
    if (es) chk({t, " rom_addr"}, int'(rom_addr), exp_addr(a, bank_m));
    @(posedge clk);
    if (w && a >= 'hFF80 && a <= 'hFF87) bank_m = a & 7;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    access('hA000, 0, 1, "R8");
    access('hC123, 0, 1, "R8");
    access('h4000, 0, 1, "R1");
    access('h5FFF, 0, 1, "R1");
    access('h6000, 0, 1, "R2");
    access('h7FFF, 0, 1, "R2");
    access('h8000, 0, 1, "R3");
    access('hE000, 0, 1, "R4");
    access('hFFFF, 0, 1, "R4");
    access('hFF85, 1, 1, "R6");
    access('hDFFF, 0, 1, "R6");
    access('hA000, 0, 1, "R5");
    access('hFF7F, 1, 1, "R7");
    access('hFF88, 1, 1, "R7");
    access('h8000, 1, 1, "R7");
    access('hB000, 0, 1, "R7");
    access('hFF82, 0, 1, "R11");
    access('hB000, 0, 1, "R11");
    access('hFF87, 1, 1, "R6");
    access('hC000, 0, 1, "R6");
    access('hFF80, 1, 0, "R6");
    access('hA555, 0, 1, "R6");
    access('h1000, 0, 1, "R10");
    access('h3FFF, 0, 0, "R10");
    access('hFFF0, 0, 0, "R9");
    access('hF000, 0, 0, "R9");
    access('hEFFF, 0, 0, "R9");

    for (int i = 0; i < 4000; i++) begin
      int sel, a;
      bit w, c;
      sel = $urandom % 4;
      if (sel == 0)      a = 'hFF80 + ($urandom % 8);
      else if (sel == 1) a = 'hFF78 + ($urandom % 24);
      else               a = $urandom % 'h10000;
      w = ($urandom % 3) == 0;
      c = ($urandom % 4) != 0;
      access(a, w, c);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule